// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block lays a 64x64 two-plane monochrome cursor over a stream of 32-bit pixels on their way to the display. For every cursor line it reads 16 pattern bytes from video memory into a small line buffer while the line is still blanked. The first 8 bytes form the AND plane and the next 8 bytes form the XOR plane. As pixels pass, each pixel inside the cursor window is painted with one of two programmable 24-bit colours, left as it is, or bit-inverted, depending on its pair of mask bits.

Software programs a cursor base address, a position, two colours, an enable bit and the horizontal and vertical display extents through a simple write port. These values reach the live drawing state only at a frame start, so a frame is never torn. A lock bit holds the cursor image, position and colours across frame starts. Clearing the lock through a position write reloads those values at once. Drawing is clipped at the right edge of the active display, and lines past the vertical display end are skipped.

Top module: `hwcur_overlay`

## Requirements
- R1: During and straight after reset, pix_out_valid, pix_out and mem_req are all zero.
- R2: pix_out_valid repeats pix_valid one cycle later. A pixel that falls outside the drawn cursor leaves unchanged, one cycle after it entered.
- R3: A cursor pixel whose AND bit is 0 becomes {8'hFF, colour}. The colour is colour0 (select 2, bits 23:0) when its XOR bit is 0, and colour1 (select 3, bits 23:0) when its XOR bit is 1.
- R4: A cursor pixel whose AND bit is 1 passes unchanged when its XOR bit is 0, and is inverted in every one of its 32 bits when its XOR bit is 1.
- R5: A line fetch for cursor row r issues exactly 16 byte reads, at base + 16*r + k with k = 0..15 in order. Bytes 0..7 hold the AND plane and bytes 8..15 the XOR plane. Bit 7 of byte k covers cursor column 8k.
- R6: The position register (select 1) holds X in bits 29:16 and Y in bits 11:0. A pixel is drawn only when its line lies in [Y, Y+64) and its column lies in [X, X+64).
- R7: When the live enable bit (select 4, bit 0) is 0, no pixel is altered and a line fetch issues no memory read.
- R8: No pixel at column x >= (h+1)*8 is altered, where h is select 5 bits 26:16. The cursor does not wrap onto the next line.
- R9: A line y greater than the vertical end (select 6 bits 27:16) is neither fetched nor drawn.
- R10: Register writes do not change drawing until the next frame_start pulse.
- R11: Select 0 holds the base in bits 26:4 and the lock in bit 31. A position write also sets or clears the lock from its bit 31. While the lock is set, a frame_start leaves base, position and colours unchanged, but enable and extents still update.
- R12: A position write with bit 31 clear, while the lock is set, reloads base, position and colours into the live state within two cycles, without a frame_start.
- R13: At most one memory read is outstanding. A new request follows only after the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base/lock, 1 position, 2 colour0, 3 colour1, 4 control, 5 horizontal extent, 6 vertical end |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Pulse at frame start; loads the live drawing state |
| line_fetch | input | 1 | Pulse in blanking to prefetch the pattern of the next line |
| line_fetch_y | input | 12 | Line number for the prefetch |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | AW | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 14 | Column of the input pixel |
| pix_in | input | 32 | Background pixel |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 32 | Pixel with the cursor applied |

## Verification
The checker watches every cycle for the fixed one-cycle pixel latency and for bypass of pixels outside the cursor. It also checks the forced 0xFF top byte on coloured pixels, the transparent and invert results, right-edge clipping, a single outstanding read, and the absence of reads while the cursor is disabled. It also checks that the live position changes only at an unlocked frame start or on an unlock reload. The exact mapping of pattern bits to columns, the fetch addresses and the vertical window can only be shown by the bench's pixel sweeps against an arithmetic model. So can shadowing until frame start and the effect of the lock on a frame start, since they depend on register histories.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_POS   = 3'd1,
    SEL_CLR0  = 3'd2,
    SEL_CLR1  = 3'd3,
    SEL_CTRL  = 3'd4,
    SEL_HEXT  = 3'd5,
    SEL_VEND  = 3'd6
  } csel_e;

  localparam logic [26:0] BASE_KEEP = 27'h7FF_FFF0;

  typedef struct packed {
    logic [26:0] base;
    logic [13:0] px;
    logic [11:0] py;
    logic [23:0] c0;
    logic [23:0] c1;
    logic        en;
    logic [10:0] hext;
    logic [11:0] vend;
  } cur_cfg_t;

  // visible line width in pixels from the horizontal extent field
  function automatic logic [14:0] line_width(input logic [10:0] h);
    return {1'b0, h, 3'b000} + 15'd8;
  endfunction

  // pos lies in [lo, lo+len)
  function automatic logic in_span(input logic [15:0] pos, input logic [15:0] lo,
                                   input logic [15:0] len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // two-plane decode
  function automatic logic [31:0] paint(input logic [31:0] bg, input logic a_bit,
                                        input logic x_bit, input logic [23:0] c0,
                                        input logic [23:0] c1);
    if (a_bit) return x_bit ? ~bg : bg;
    return {8'hFF, (x_bit ? c1 : c0)};
  endfunction

endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
  import hwcur_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        frame_start,
  output cur_cfg_t    act,
  output logic        lock,
  output logic        reload_apply
);

  logic [26:0] base_q;
  logic        lock_q;
  logic [13:0] px_q;
  logic [11:0] py_q;
  logic [23:0] c0_q, c1_q;
  logic        en_q;
  logic [10:0] hext_q;
  logic [11:0] vend_q;
  logic        unlock_evt;
  logic        unused_wbits;

  assign lock = lock_q;
  assign unlock_evt = wr_en && (csel_e'(wr_sel) == SEL_POS) && !wr_data[31] && lock_q;
  assign unused_wbits = ^{wr_data[30], wr_data[15:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; lock_q <= 1'b0; px_q <= '0; py_q <= '0;
      c0_q <= '0; c1_q <= '0; en_q <= 1'b0; hext_q <= '0; vend_q <= '0;
    end else if (wr_en) begin
      case (csel_e'(wr_sel))
        SEL_BASE: begin
          base_q <= wr_data[26:0] & BASE_KEEP;
          lock_q <= wr_data[31];
        end
        SEL_POS: begin
          px_q   <= wr_data[29:16];
          py_q   <= wr_data[11:0];
          lock_q <= wr_data[31];
        end
        SEL_CLR0: c0_q   <= wr_data[23:0];
        SEL_CLR1: c1_q   <= wr_data[23:0];
        SEL_CTRL: en_q   <= wr_data[0];
        SEL_HEXT: hext_q <= wr_data[26:16];
        SEL_VEND: vend_q <= wr_data[27:16];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reload_apply <= 1'b0;
    else        reload_apply <= unlock_evt;
  end

  // live copy, loaded at frame start or on an unlock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
    end else begin
      if (frame_start) begin
        act.en   <= en_q;
        act.hext <= hext_q;
        act.vend <= vend_q;
      end
      if ((frame_start && !lock_q) || reload_apply) begin
        act.base <= base_q;
        act.px   <= px_q;
        act.py   <= py_q;
        act.c0   <= c0_q;
        act.c1   <= c1_q;
      end
    end
  end

endmodule

// File: rtl/hwcur_fetch.sv
module hwcur_fetch
  import hwcur_pkg::*;
#(
  parameter int AW    = 27,
  parameter int CUR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              go,
  input  logic [11:0]       go_y,
  input  cur_cfg_t          act,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic [CUR_W-1:0]  and_row,
  output logic [CUR_W-1:0]  xor_row,
  output logic              row_ok,
  output logic              busy
);

  localparam int PB = CUR_W / 8;
  localparam int LB = 2 * PB;
  localparam int CW = $clog2(LB);
  localparam int RW = $clog2(CUR_W);

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fst_e;

  fst_e          st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] line_addr;
  logic [7:0]    buf_q [LB];
  logic [12:0]   dy;
  logic          row_hit;
  logic          unused_cfg;

  assign unused_cfg = ^{act.px, act.c0, act.c1, act.hext};

  assign dy      = {1'b0, go_y} - {1'b0, act.py};
  assign row_hit = act.en && (go_y >= act.py) && (dy < 13'(CUR_W)) && (go_y <= act.vend);

  assign mem_req  = (st == F_ISSUE);
  assign mem_addr = line_addr + AW'(cnt);
  assign busy     = (st != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= F_IDLE; cnt <= '0; line_addr <= '0; row_ok <= 1'b0;
    end else begin
      if (frame_start) row_ok <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          row_ok <= 1'b0;
          if (row_hit) begin
            line_addr <= AW'(act.base) + AW'(dy[RW-1:0]) * AW'(LB);
            cnt       <= '0;
            st        <= F_ISSUE;
          end
        end
        F_ISSUE: st <= F_WAIT;
        F_WAIT: if (mem_rvalid) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(LB - 1)) begin
            st     <= F_IDLE;
            row_ok <= 1'b1;
          end else begin
            st <= F_ISSUE;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LB; i++) buf_q[i] <= '0;
    end else if (st == F_WAIT && mem_rvalid) begin
      buf_q[cnt] <= mem_rdata;
    end
  end

  for (genvar k = 0; k < PB; k++) begin : g_byte
    for (genvar b = 0; b < 8; b++) begin : g_bit
      assign and_row[k*8 + b] = buf_q[k][7-b];
      assign xor_row[k*8 + b] = buf_q[PB + k][7-b];
    end
  end

endmodule

// File: rtl/hwcur_blend.sv
module hwcur_blend
  import hwcur_pkg::*;
#(
  parameter int CUR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [13:0]       pix_x,
  input  logic [31:0]       pix_in,
  input  cur_cfg_t          act,
  input  logic              row_ok,
  input  logic [CUR_W-1:0]  and_row,
  input  logic [CUR_W-1:0]  xor_row,
  output logic              pix_out_valid,
  output logic [31:0]       pix_out,
  output logic              hit,
  output logic              and_bit,
  output logic              xor_bit
);

  localparam int RW = $clog2(CUR_W);

  logic [RW-1:0] col;
  logic          in_win;
  logic          in_line;
  logic          unused_cfg;

  assign unused_cfg = ^{act.base, act.py, act.vend};

  assign col     = RW'(pix_x - act.px);
  assign in_win  = in_span({2'b00, pix_x}, {2'b00, act.px}, 16'(CUR_W));
  assign in_line = {1'b0, pix_x} < line_width(act.hext);
  assign hit     = pix_valid && row_ok && act.en && in_win && in_line;
  assign and_bit = and_row[col];
  assign xor_bit = xor_row[col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out_valid <= 1'b0;
      pix_out       <= '0;
    end else begin
      pix_out_valid <= pix_valid;
      if (pix_valid)
        pix_out <= hit ? paint(pix_in, and_bit, xor_bit, act.c0, act.c1) : pix_in;
    end
  end

endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int AW    = 27,
  parameter int CUR_W = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          frame_start,
  input  logic          line_fetch,
  input  logic [11:0]   line_fetch_y,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  input  logic          pix_valid,
  input  logic [13:0]   pix_x,
  input  logic [31:0]   pix_in,
  output logic          pix_out_valid,
  output logic [31:0]   pix_out
);

  cur_cfg_t          act_cfg;
  logic              cfg_lock;
  logic              reload_apply;
  logic [CUR_W-1:0]  and_row, xor_row;
  logic              row_ok, fetch_busy;
  logic              ovl_hit, ovl_and, ovl_xor;
  logic              act_en;
  logic [10:0]       act_hext;
  logic [25:0]       act_pos;

  assign act_en   = act_cfg.en;
  assign act_hext = act_cfg.hext;
  assign act_pos  = {act_cfg.px, act_cfg.py};

  hwcur_regs u_regs (
    .clk, .rst_n,
    .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .frame_start,
    .act(act_cfg), .lock(cfg_lock), .reload_apply(reload_apply)
  );

  hwcur_fetch #(.AW(AW), .CUR_W(CUR_W)) u_fetch (
    .clk, .rst_n, .frame_start,
    .go(line_fetch), .go_y(line_fetch_y), .act(act_cfg),
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .and_row, .xor_row, .row_ok, .busy(fetch_busy)
  );

  hwcur_blend #(.CUR_W(CUR_W)) u_blend (
    .clk, .rst_n, .pix_valid, .pix_x, .pix_in,
    .act(act_cfg), .row_ok, .and_row, .xor_row,
    .pix_out_valid, .pix_out,
    .hit(ovl_hit), .and_bit(ovl_and), .xor_bit(ovl_xor)
  );

endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_valid,
  input logic [13:0] pix_x,
  input logic [31:0] pix_in,
  input logic [31:0] pix_out,
  input logic        pix_out_valid,
  input logic        ovl_hit,
  input logic        ovl_and,
  input logic        ovl_xor,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        act_en,
  input logic [10:0] act_hext,
  input logic [25:0] act_pos,
  input logic        frame_start,
  input logic        cfg_lock,
  input logic        reload_apply
);

  logic        outstanding;
  logic [14:0] edge_x;

  assign edge_x = ({1'b0, act_hext, 3'b000}) + 15'd8;

  always_ff @(posedge clk) begin
    if (!rst_n)          outstanding <= 1'b0;
    else if (mem_req)    outstanding <= 1'b1;
    else if (mem_rvalid) outstanding <= 1'b0;
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out_valid == $past(pix_valid));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !ovl_hit) |=> (pix_out == $past(pix_in)));

  p_alpha_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_hit && !ovl_and) |=> (pix_out[31:24] == 8'hFF));

  p_transp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_hit && ovl_and && !ovl_xor) |=> (pix_out == $past(pix_in)));

  p_invert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_hit && ovl_and && ovl_xor) |=> (pix_out == ~$past(pix_in)));

  p_no_fetch_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> act_en);

  p_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_hit |-> ({1'b0, pix_x} < edge_x));

  p_pos_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pos != $past(act_pos)) |-> ($past(frame_start && !cfg_lock) || $past(reload_apply)));

  p_one_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!outstanding || mem_rvalid));

endmodule

bind hwcur_overlay hwcur_overlay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
  .pix_in(pix_in), .pix_out(pix_out), .pix_out_valid(pix_out_valid),
  .ovl_hit(ovl_hit), .ovl_and(ovl_and), .ovl_xor(ovl_xor),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .act_en(act_en),
  .act_hext(act_hext), .act_pos(act_pos), .frame_start(frame_start),
  .cfg_lock(cfg_lock), .reload_apply(reload_apply)
);

// File: tb/tb_hwcur_overlay.sv
module tb_hwcur_overlay;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic          frame_start = 1'b0;
  logic          line_fetch = 1'b0;
  logic [11:0]   line_fetch_y = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [7:0]    mem_rdata;
  logic          pix_valid = 1'b0;
  logic [13:0]   pix_x = '0;
  logic [31:0]   pix_in = '0;
  logic          pix_out_valid;
  logic [31:0]   pix_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwcur_overlay #(.AW(AW)) dut (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .frame_start,
    .line_fetch, .line_fetch_y, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .pix_valid, .pix_x, .pix_in, .pix_out_valid, .pix_out
  );

  // video memory: arithmetic content, two-cycle response
  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 29) ^ (a >> 2) ^ 90);
  endfunction

  logic          m_d1;
  logic [AW-1:0] m_a1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 <= 1'b0; m_a1 <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      m_d1 <= mem_req;
      m_a1 <= mem_addr;
      mem_rvalid <= m_d1;
      mem_rdata  <= mem_byte(int'(m_a1));
    end
  end

  // programmed and live model state
  int m_base, m_x, m_y, m_c0, m_c1, m_en, m_h, m_v, m_lock;
  int a_base, a_x, a_y, a_c0, a_c1, a_en, a_h, a_v;
  int row_hit, row_idx;

  function automatic logic [31:0] pin(input int x, input int y);
    return 32'(x * 40503) ^ 32'(y << 18) ^ 32'hC3A5_1E0F;
  endfunction

  task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_live();
    a_base = m_base; a_x = m_x; a_y = m_y; a_c0 = m_c0; a_c1 = m_c1;
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    int was_locked;
    was_locked = m_lock;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (sel)
      0: begin m_base = int'(d & 32'h07FF_FFF0); m_lock = int'(d[31]); end
      1: begin m_x = int'(d[29:16]); m_y = int'(d[11:0]); m_lock = int'(d[31]); end
      2: m_c0 = int'(d[23:0]);
      3: m_c1 = int'(d[23:0]);
      4: m_en = int'(d[0]);
      5: m_h  = int'(d[26:16]);
      6: m_v  = int'(d[27:16]);
      default: ;
    endcase
    if (sel == 1 && was_locked == 1 && d[31] == 1'b0) load_live();
    idle(3);
  endtask

  task automatic sof();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    a_en = m_en; a_h = m_h; a_v = m_v;
    if (m_lock == 0) load_live();
    row_hit = 0;
  endtask

  task automatic fetch(input int y);
    int nreq;
    @(negedge clk); line_fetch = 1'b1; line_fetch_y = 12'(y);
    @(negedge clk); line_fetch = 1'b0;
    row_hit = (a_en != 0 && y >= a_y && y < a_y + 64 && y <= a_v) ? 1 : 0;
    row_idx = y - a_y;
    nreq = 0;
    for (int i = 0; i < 70; i++) begin
      if (mem_req) begin
        // R5: address order base + 16*row + k
        check("R5 fetch address", 32'(mem_addr), 32'(a_base + row_idx * 16 + nreq));
        nreq++;
      end
      @(negedge clk);
    end
    // R13 one read per byte, 16 per cursor line; R7 and R9 none otherwise
    check(row_hit != 0 ? "R13 read count" : "R7 R9 no reads", 32'(nreq), 32'(row_hit != 0 ? 16 : 0));
  endtask

  function automatic logic [31:0] expect_pix(input int x, input int y, output string cat);
    logic [31:0] bg;
    int col, ad, ab, xb;
    bg = pin(x, y);
    cat = "R2 bypass";
    if (row_hit != 0 && a_en != 0 && x >= a_x && x < a_x + 64 && x < (a_h + 1) * 8) begin
      col = x - a_x;
      ad  = a_base + row_idx * 16 + col / 8;
      ab  = (int'(mem_byte(ad)) >> (7 - col % 8)) & 1;
      xb  = (int'(mem_byte(ad + 8)) >> (7 - col % 8)) & 1;
      if (ab == 1) begin
        cat = "R4 and-set";
        return (xb == 1) ? ~bg : bg;
      end
      cat = "R3 colour";
      return {8'hFF, 24'((xb == 1) ? a_c1 : a_c0)};
    end
    return bg;
  endfunction

  task automatic line(input string tag, input int y, input int x0, input int x1);
    string cat;
    logic [31:0] ex;
    fetch(y);
    for (int x = x0; x <= x1 + 1; x++) begin
      @(negedge clk);
      if (x > x0) begin
        ex = expect_pix(x - 1, y, cat);
        check({tag, " ", cat}, pix_out, ex);
        check("R2 valid", 32'(pix_out_valid), 32'd1);
      end
      if (x <= x1) begin
        pix_valid = 1'b1; pix_x = 14'(x); pix_in = pin(x, y);
      end else begin
        pix_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 valid drop", 32'(pix_out_valid), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_base = 0; m_x = 0; m_y = 0; m_c0 = 0; m_c1 = 0; m_en = 0; m_h = 0; m_v = 0; m_lock = 0;
    a_base = 0; a_x = 0; a_y = 0; a_c0 = 0; a_c1 = 0; a_en = 0; a_h = 0; a_v = 0;
    row_hit = 0; row_idx = 0;
    idle(4);
    // R1 reset values
    check("R1 pix_out_valid", 32'(pix_out_valid), 32'd0);
    check("R1 pix_out", pix_out, 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R1 after release", {31'd0, mem_req | pix_out_valid}, 32'd0);

    // program a cursor; not live until frame start (R10, R7)
    wr(0, 32'h0000_1230);
    wr(1, {2'b00, 14'd10, 4'd0, 12'd5});
    wr(2, 32'h0011_2233);
    wr(3, 32'hFFA0_B0C0);
    wr(4, 32'h1);
    wr(5, {5'd0, 11'd11, 16'd0});
    wr(6, {4'd0, 12'd200, 16'd0});
    line("R10 before frame start", 6, 0, 95);

    // full sweep across the vertical window (R3 R4 R5 R6)
    sof();
    for (int y = 3; y <= 70; y++) line("R6 window sweep", y, 0, 95);

    // mid-frame colour change waits for frame start (R10)
    wr(2, 32'h0055_6677);
    line("R10 old colour", 9, 0, 95);
    sof();
    line("R10 new colour", 9, 0, 95);

    // right-edge clip (R8)
    wr(1, {2'b00, 14'd60, 4'd0, 12'd0});
    sof();
    for (int y = 0; y <= 2; y++) line("R8 clip", y, 0, 95);
    wr(1, {2'b00, 14'd90, 4'd0, 12'd0});
    sof();
    line("R8 clip far", 1, 0, 95);

    // vertical end (R9)
    wr(1, {2'b00, 14'd20, 4'd0, 12'd0});
    wr(6, {4'd0, 12'd2, 16'd0});
    sof();
    for (int y = 0; y <= 4; y++) line("R9 vertical end", y, 0, 95);
    wr(6, {4'd0, 12'd300, 16'd0});

    // lock: new position and base ignored at frame start, extents still load (R11)
    wr(1, {1'b1, 1'b0, 14'd40, 4'd0, 12'd8});
    wr(0, 32'h8000_0400);
    wr(3, 32'h0001_0203);
    wr(5, {5'd0, 11'd9, 16'd0});
    sof();
    for (int y = 8; y <= 11; y++) line("R11 locked", y, 0, 95);

    // unlock through a position write reloads at once (R12)
    wr(1, {2'b00, 14'd30, 4'd0, 12'd8});
    for (int y = 8; y <= 11; y++) line("R12 unlock reload", y, 0, 95);

    // disable: no reads, no overlay (R7)
    wr(4, 32'h0);
    sof();
    for (int y = 8; y <= 10; y++) line("R7 disabled", y, 0, 95);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule